// File: doc/BRIEF.md
# Soft-Start, Overload and Skip/Latch Monitor

This block sits in the digital core of a current-mode flyback controller. It works on ADC codes of two analog pins: the feedback pin, which an optocoupler pulls down as load falls, and a shared pin that both sets the light-load skip level and, when it is pulled high, latches the converter off. A free-running time tick, one per microsecond by default, paces every timer. A one-cycle start request begins a new soft-start ramp.

The block produces the modulation code that the current comparator uses. That code is the lower of a soft-start ramp and one third of the feedback code. Three conditions are watched alongside it. A sustained feedback overload raises a fault once a retriggerable timer expires. Feedback below an adjustable, clamped skip level raises a skip request with hysteresis. A shared-pin level above the latch threshold raises a latch fault once it survives a spike filter. All codes use a 5 mV LSB, so 1.0 V is code 200.

Top module: `pwm_monitor`

## Requirements
- R1: After reset the modulation code is 0 and the overload fault, skip request and latch fault are all low.
- R2: A start request resets the soft-start ramp to 0. The ramp then rises by one code every SS_STEP_TICKS ticks until it reaches SS_FULL (code 200), and it holds there.
- R3: One cycle after its inputs, the modulation code equals the lower of the ramp and floor(feedback/3).
- R4: Feedback strictly above OVL_CODE (code 600) for OVL_TICKS consecutive ticks raises the overload fault. A single cycle at or below that code restarts the count from zero.
- R5: The overload fault stays high after the overload ends. Only a start request clears it, one cycle after the request.
- R6: The skip threshold equals the shared-pin code, capped at SKIP_MAX (code 260). An open pin reads code 220, which gives a 1.1 V threshold.
- R7: The skip request rises one cycle after feedback + SKIP_HYS (15 codes) drops below the threshold. It falls one cycle after feedback rises strictly above the threshold, and it holds its value in between.
- R8: A shared-pin code strictly above LATCH_CODE (code 780) for LATCH_TICKS consecutive ticks raises the latch fault. A single cycle at or below that code restarts the filter.
- R9: The latch fault stays high until reset. A start request does not clear it.
- R10: The timers advance only on cycles where the tick is high. With the tick held low, an overload of any length raises no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base pulse, one cycle wide |
| ss_start | input | 1 | Start request: restart soft-start, clear overload fault |
| fb_code | input | CODE_W | Feedback pin ADC code |
| pin_code | input | CODE_W | Skip/latch pin ADC code |
| mod_code | output | CODE_W | Modulation level for the current comparator |
| ovl_fault | output | 1 | Overload timer expired |
| skip_req | output | 1 | Skip the next switching cycles |
| latch_fault | output | 1 | External latch-off request, filtered |

## Verification
A ramp prescaler that is off by one shows up as a modulation code that lags or leads the expected staircase. The bench reads the staircase at exact cycle counts after a start request, so one extra or missing step is visible within a few ticks. A timer that fails to clear on a short dip, or that counts without a tick, raises a fault several cycles early, and this is checked at the cycle just before the expected edge. A skip comparator with a wrong threshold or hysteresis side, or with a wrong clamp, shows a wrong skip level one cycle after a boundary feedback code is applied.

// File: rtl/pwm_mon_pkg.sv
package pwm_mon_pkg;
  // ADC resolution in microvolts per code
  parameter int unsigned LSB_UV = 5000;

  function automatic int unsigned mv_to_code(input int unsigned mv);
    return (mv * 1000) / LSB_UV;
  endfunction
endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int unsigned CODE_W        = 10,
  parameter int unsigned SS_FULL       = 200,
  parameter int unsigned SS_STEP_TICKS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [CODE_W-1:0] fb_code,
  output logic [CODE_W-1:0] mod_code
);
  localparam int unsigned       STEP_W    = $clog2(SS_STEP_TICKS + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEP_TICKS - 1);
  localparam logic [CODE_W-1:0] FULL_C    = CODE_W'(SS_FULL);

  logic [STEP_W-1:0] pre_q, pre_d;
  logic [CODE_W-1:0] ss_q, ss_d;
  logic [CODE_W-1:0] mod_q, mod_d;
  logic [CODE_W-1:0] fb_third;
  logic              step_en;

  assign fb_third = CODE_W'(fb_code / CODE_W'(3));
  assign step_en  = tick && (ss_q < FULL_C);

  always_comb begin
    pre_d = pre_q;
    ss_d  = ss_q;
    if (start) begin
      pre_d = '0;
      ss_d  = '0;
    end else if (step_en) begin
      if (pre_q == STEP_LAST) begin
        pre_d = '0;
        ss_d  = ss_q + CODE_W'(1);
      end else begin
        pre_d = pre_q + STEP_W'(1);
      end
    end
    mod_d = (fb_third < ss_q) ? fb_third : ss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ss_q  <= '0;
      mod_q <= '0;
    end else begin
      pre_q <= pre_d;
      ss_q  <= ss_d;
      mod_q <= mod_d;
    end
  end

  assign mod_code = mod_q;

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ss_q == '0));
  // R2
  ss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (ss_q == $past(ss_q)) || (ss_q == $past(ss_q) + CODE_W'(1)));
  // R3
  mod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mod_q <= $past(ss_q)) && (mod_q <= $past(fb_third)));
endmodule

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  input  logic clr,
  output logic fault
);
  localparam int unsigned      CNT_W  = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flt_q, flt_d;
  logic             cnt_en;

  assign cnt_en = cond && tick && (cnt_q != LIM_C);

  always_comb begin
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (clr || !cond) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (clr) begin
      flt_d = 1'b0;
    end else if (cnt_en && (cnt_q == LAST_C)) begin
      flt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign fault = flt_q;

  // R4 R8
  dip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> (cnt_q == '0));
  // R4 R8
  rise_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(cond) && $past(tick));
  // R5 R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && !clr) |=> flt_q);
endmodule

// File: rtl/skip_detect.sv
module skip_detect #(
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned SKIP_MAX = 260,
  parameter int unsigned SKIP_HYS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] pin_code,
  output logic              skip_req
);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(SKIP_MAX);
  localparam logic [CODE_W:0]   HYS_C = (CODE_W+1)'(SKIP_HYS);

  logic [CODE_W-1:0] thr;
  logic              go_low, go_high;
  logic              skip_q, skip_d;

  assign thr     = (pin_code > MAX_C) ? MAX_C : pin_code;
  assign go_low  = ({1'b0, fb_code} + HYS_C) < {1'b0, thr};
  assign go_high = fb_code > thr;

  always_comb begin
    skip_d = skip_q;
    if (!skip_q && go_low) begin
      skip_d = 1'b1;
    end else if (skip_q && go_high) begin
      skip_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= skip_d;
  end

  assign skip_req = skip_q;

  // R7
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && (fb_code <= thr)) |=> skip_q);
  // R7
  skip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_code > MAX_C) |=> !skip_q);
endmodule

// File: rtl/pwm_monitor.sv
module pwm_monitor
  import pwm_mon_pkg::*;
#(
  parameter int unsigned CODE_W        = 10,
  parameter int unsigned SS_FULL       = mv_to_code(1000),
  parameter int unsigned SS_STEP_TICKS = 24,
  parameter int unsigned OVL_CODE      = mv_to_code(3000),
  parameter int unsigned OVL_TICKS     = 118000,
  parameter int unsigned SKIP_MAX      = mv_to_code(1300),
  parameter int unsigned SKIP_HYS      = mv_to_code(75),
  parameter int unsigned LATCH_CODE    = mv_to_code(3900),
  parameter int unsigned LATCH_TICKS   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ss_start,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] pin_code,
  output logic [CODE_W-1:0] mod_code,
  output logic              ovl_fault,
  output logic              skip_req,
  output logic              latch_fault
);
  localparam logic [CODE_W-1:0] OVL_C   = CODE_W'(OVL_CODE);
  localparam logic [CODE_W-1:0] LATCH_C = CODE_W'(LATCH_CODE);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       ovl_cond, latch_cond;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign ovl_cond   = fb_code > OVL_C;
  assign latch_cond = pin_code > LATCH_C;

  ss_ramp #(
    .CODE_W(CODE_W), .SS_FULL(SS_FULL), .SS_STEP_TICKS(SS_STEP_TICKS)
  ) u_ramp (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .start(ss_start),
    .fb_code(fb_code), .mod_code(mod_code)
  );

  persist_filter #(.LIMIT(OVL_TICKS)) u_ovl (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .cond(ovl_cond),
    .clr(ss_start), .fault(ovl_fault)
  );

  persist_filter #(.LIMIT(LATCH_TICKS)) u_latch (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .cond(latch_cond),
    .clr(1'b0), .fault(latch_fault)
  );

  skip_detect #(
    .CODE_W(CODE_W), .SKIP_MAX(SKIP_MAX), .SKIP_HYS(SKIP_HYS)
  ) u_skip (
    .clk(clk), .rst_n(rst_core_n), .fb_code(fb_code), .pin_code(pin_code),
    .skip_req(skip_req)
  );
endmodule

// File: tb/pwm_monitor_test.sv
module pwm_monitor_test;
  localparam int W = 10;

  logic         clk;
  logic         rst_n;
  logic         tick;
  logic         ss_start;
  logic [W-1:0] fb_code;
  logic [W-1:0] pin_code;
  logic [W-1:0] mod_code;
  logic         ovl_fault;
  logic         skip_req;
  logic         latch_fault;

  int n_tests;
  int n_fail;
  bit done;

  pwm_monitor #(
    .CODE_W(W), .SS_STEP_TICKS(3), .OVL_TICKS(20), .LATCH_TICKS(6)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ss_start(ss_start),
    .fb_code(fb_code), .pin_code(pin_code), .mod_code(mod_code),
    .ovl_fault(ovl_fault), .skip_req(skip_req), .latch_fault(latch_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    ss_start = 1'b1;
    wait_cyc(1);
    ss_start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b1; ss_start = 1'b0;
    fb_code = 10'd600; pin_code = 10'd220;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 mod", int'(mod_code), 0);
    check("R1 ovl", int'(ovl_fault), 0);
    check("R1 skip", int'(skip_req), 0);
    check("R1 latch", int'(latch_fault), 0);
  endtask

  task automatic t_softstart();
    pulse_start();             // now m=1
    wait_cyc(1);               // m=2
    check("R2 ramp start", int'(mod_code), 0);
    wait_cyc(9);               // m=11
    check("R2 ramp m11", int'(mod_code), 3);
    wait_cyc(591);             // m=602
    check("R2 ramp full", int'(mod_code), 200);
    wait_cyc(98);              // m=700
    check("R2 ramp hold", int'(mod_code), 200);
    fb_code = 10'd90;
    wait_cyc(1);
    check("R3 fb limits", int'(mod_code), 30);
    fb_code = 10'd600;
    wait_cyc(1);
    check("R3 ramp limits", int'(mod_code), 200);
    pulse_start();
    wait_cyc(1);
    check("R2 restart zero", int'(mod_code), 0);
    wait_cyc(12);              // m=14
    check("R2 restart m14", int'(mod_code), 4);
    wait_cyc(700);
  endtask

  task automatic t_overload();
    fb_code = 10'd900;
    wait_cyc(19);
    check("R4 before expiry", int'(ovl_fault), 0);
    wait_cyc(1);
    check("R4 expiry", int'(ovl_fault), 1);
    check("R3 overload mod", int'(mod_code), 200);
    fb_code = 10'd300;
    wait_cyc(5);
    check("R5 sticky", int'(ovl_fault), 1);
    pulse_start();
    check("R5 cleared", int'(ovl_fault), 0);
    fb_code = 10'd900;
    wait_cyc(15);
    fb_code = 10'd100;
    wait_cyc(1);
    fb_code = 10'd900;
    wait_cyc(19);
    check("R4 dip restarts", int'(ovl_fault), 0);
    wait_cyc(1);
    check("R4 after dip", int'(ovl_fault), 1);
    fb_code = 10'd300;
    pulse_start();
    tick = 1'b0;
    fb_code = 10'd900;
    wait_cyc(40);
    check("R10 no tick", int'(ovl_fault), 0);
    tick = 1'b1;
    wait_cyc(19);
    check("R10 ticks resume", int'(ovl_fault), 0);
    wait_cyc(1);
    check("R10 expiry", int'(ovl_fault), 1);
    fb_code = 10'd300;
    pulse_start();
  endtask

  task automatic skip_step(input string req, input int pin, input int fb, input int exp);
    pin_code = W'(pin);
    fb_code  = W'(fb);
    wait_cyc(1);
    check(req, int'(skip_req), exp);
  endtask

  task automatic t_skip();
    skip_step("R7 above", 220, 300, 0);
    skip_step("R7 inside band", 220, 206, 0);
    skip_step("R6 open pin entry", 220, 204, 1);
    skip_step("R7 hold at thr", 220, 220, 1);
    skip_step("R7 release", 220, 221, 0);
    skip_step("R6 clamp band", 500, 246, 0);
    skip_step("R6 clamp entry", 500, 244, 1);
    skip_step("R6 clamp hold", 500, 260, 1);
    skip_step("R6 clamp release", 500, 261, 0);
    skip_step("R6 low pin band", 100, 86, 0);
    skip_step("R6 low pin entry", 100, 84, 1);
    skip_step("R7 low pin release", 100, 101, 0);
  endtask

  task automatic t_latch();
    fb_code = 10'd300;
    pin_code = 10'd781;
    wait_cyc(4);
    pin_code = 10'd780;
    wait_cyc(1);
    pin_code = 10'd781;
    wait_cyc(5);
    check("R8 filter restart", int'(latch_fault), 0);
    wait_cyc(1);
    check("R8 latch set", int'(latch_fault), 1);
    pin_code = 10'd0;
    pulse_start();
    wait_cyc(3);
    check("R9 latch held", int'(latch_fault), 1);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    t_reset();
    t_softstart();
    t_overload();
    t_skip();
    t_latch();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule